// File: doc/BRIEF.md
# Write-Gated Seconds Prescaler

This block turns the 32.768 kHz timekeeping clock into a one-second tick for a real-time clock. It also decides when timekeeping may start. A software enable bit controls whether writes from the serial host to the time registers are let through. Only writes that are let through are forwarded to the calendar registers.

Timekeeping stays stopped after reset. It starts at the bus STOP condition that closes a transaction in which an accepted time-register write took place. At that same STOP the prescaler is cleared, so the new second begins at the moment the host finishes setting the time. Every later STOP that closes such a transaction re-aligns the phase in the same way. A STOP with no accepted write before it leaves the prescaler alone. Once timekeeping has started, it runs until the next reset.

The calendar counters and the bus protocol decoder are not part of this block. The STOP pulse is one clock cycle wide and synchronous to the 32.768 kHz clock. The divider width is a parameter, `DIV_BITS`, with a default of 15, which gives a period of 32768 cycles.

Top module: `rtc_second_gate`

## Requirements
- R1: While reset is asserted, and directly after it is released, `secTick` and `counting` are 0.
- R2: `wrAccept` is a combinational copy of `timeWrStb` in the same cycle when `wrEnable` is 1, and it is 0 when `wrEnable` is 0.
- R3: A time write presented while `wrEnable` is 0 is not accepted. The STOP that follows it neither starts timekeeping nor moves the tick phase.
- R4: `counting` goes from 0 to 1 on the clock edge that samples a STOP pulse closing a transaction in which a write was accepted. An accepted write in the same cycle as the STOP also counts as part of that transaction.
- R5: The first `secTick` after a start is asserted by the clock edge that comes 2^DIV_BITS edges after the edge that sampled the STOP. It is exactly one cycle wide.
- R6: While counting, successive `secTick` pulses are exactly 2^DIV_BITS cycles apart.
- R7: A qualifying STOP (as in R4) that arrives while already counting clears the phase. The next tick then follows that STOP as in R5, and the tick that was previously due does not appear.
- R8: A STOP with no accepted write since the previous STOP leaves the tick schedule unchanged.
- R9: Once `counting` is 1 it stays 1 until reset, even if `wrEnable` is cleared.
- R10: `secTick` is never 1 while `counting` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 32.768 kHz timekeeping clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEnable | input | 1 | Software bit that allows writes to the time registers |
| timeWrStb | input | 1 | One-cycle strobe for a host write to a time register |
| stopPulse | input | 1 | One-cycle pulse at the bus STOP condition |
| wrAccept | output | 1 | Gated write strobe forwarded to the calendar registers |
| secTick | output | 1 | One-cycle pulse once per second |
| counting | output | 1 | High once timekeeping has started |

## Verification
A pending-write flag that is stuck or lost shows up within one cycle of the next STOP. The symptom is either a `counting` rise that should not happen, or a missing rise. A wrong clear or increment in the prescaler does not show until the next expected tick, up to 2^DIV_BITS cycles later. There it appears as a tick that is early, late or missing. For this reason the phase checks measure the exact edge count from the STOP to each tick, both right after a re-alignment and right after a bare STOP.

// File: rtl/rtc_gate_pkg.sv
package rtc_gate_pkg;
  // Strobes from the control half to the prescaler datapath
  typedef struct packed {
    logic clrPhase;  // restart the second at this STOP
    logic advance;   // count one 32.768 kHz cycle
  } phaseCmd_t;
endpackage

// File: rtl/rtc_gate_ctrl.sv
module rtc_gate_ctrl
  import rtc_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrEnable,
  input  logic      timeWrStb,
  input  logic      stopPulse,
  output logic      wrAccept,
  output logic      counting,
  output phaseCmd_t cmd
);
  logic pendingQ;
  logic countingQ;
  logic startNow;

  assign wrAccept = timeWrStb & wrEnable;
  assign startNow = stopPulse & (pendingQ | wrAccept);

  // Remember that the current transaction carried an accepted write
  always_ff @(posedge clk) begin
    if (!rstN)          pendingQ <= 1'b0;
    else if (stopPulse) pendingQ <= 1'b0;
    else if (wrAccept)  pendingQ <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) countingQ <= 1'b0;
    else       countingQ <= countingQ | startNow;
  end

  assign counting     = countingQ;
  assign cmd.clrPhase = startNow;
  assign cmd.advance  = countingQ & ~startNow;

  AST_COUNT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    countingQ |=> countingQ);  // R9
  AST_START_ON_STOP: assert property (@(posedge clk) disable iff (!rstN)
    $rose(countingQ) |-> $past(stopPulse));  // R4
  AST_BARE_STOP_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stopPulse && !pendingQ && !wrAccept && !countingQ) |=> !countingQ);  // R3
endmodule

// File: rtl/rtc_gate_prescale.sv
module rtc_gate_prescale
  import rtc_gate_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic      clk,
  input  logic      rstN,
  input  phaseCmd_t cmd,
  output logic      tick
);
  localparam logic [DIV_BITS-1:0] CNT_MAX = '1;

  logic [DIV_BITS-1:0] cnt;
  logic                tickQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt   <= '0;
      tickQ <= 1'b0;
    end else if (cmd.clrPhase) begin
      cnt   <= '0;
      tickQ <= 1'b0;
    end else if (cmd.advance) begin
      cnt   <= cnt + 1'b1;
      tickQ <= (cnt == CNT_MAX);
    end else begin
      tickQ <= 1'b0;
    end
  end

  assign tick = tickQ;

  AST_CLEAR_PHASE: assert property (@(posedge clk) disable iff (!rstN)
    cmd.clrPhase |=> (cnt == '0 && !tickQ));  // R7
  AST_TICK_AT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    tickQ |-> (cnt == '0 && $past(cnt) == CNT_MAX));  // R6
  AST_TICK_ONE_WIDE: assert property (@(posedge clk) disable iff (!rstN)
    tickQ |=> !tickQ);  // R5
endmodule

// File: rtl/rtc_second_gate.sv
module rtc_second_gate
  import rtc_gate_pkg::*;
#(
  parameter int DIV_BITS = 15
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEnable,
  input  logic timeWrStb,
  input  logic stopPulse,
  output logic wrAccept,
  output logic secTick,
  output logic counting
);
  phaseCmd_t cmd;

  rtc_gate_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEnable  (wrEnable),
    .timeWrStb (timeWrStb),
    .stopPulse (stopPulse),
    .wrAccept  (wrAccept),
    .counting  (counting),
    .cmd       (cmd)
  );

  rtc_gate_prescale #(.DIV_BITS(DIV_BITS)) u_pre (
    .clk  (clk),
    .rstN (rstN),
    .cmd  (cmd),
    .tick (secTick)
  );

  AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !counting |-> !secTick);  // R10
endmodule

// File: tb/rtc_second_gate_tb.sv
`timescale 1ns/1ps
module rtc_second_gate_tb;
  localparam int DB = 10;
  localparam int P  = 1 << DB;

  logic clk = 1'b0;
  logic rstN, wrEnable, timeWrStb, stopPulse;
  logic wrAccept, secTick, counting;
  int   total = 0;
  int   bad   = 0;
  int   cyc   = 0;
  bit   done  = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rtc_second_gate #(.DIV_BITS(DB)) u_dut (
    .clk(clk), .rstN(rstN), .wrEnable(wrEnable), .timeWrStb(timeWrStb),
    .stopPulse(stopPulse), .wrAccept(wrAccept), .secTick(secTick),
    .counting(counting)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // drive a one-cycle STOP (optionally with an earlier write); returns cyc at the drive negedge
  task automatic doStop(input bit withWrite, output int atCyc);
    if (withWrite) begin
      timeWrStb = 1'b1;
      @(negedge clk);
      timeWrStb = 1'b0;
      waitCycles(2);
    end
    stopPulse = 1'b1;
    atCyc = cyc;
    @(negedge clk);
    stopPulse = 1'b0;
  endtask

  // wait for the next tick; returns cyc when seen, -1 on none
  task automatic nextTick(output int atCyc);
    atCyc = -1;
    for (int i = 0; i < 3 * P; i++) begin
      if (secTick) begin atCyc = cyc; break; end
      @(negedge clk);
    end
  endtask

  task automatic tReset;
    rstN = 1'b0; wrEnable = 1'b0; timeWrStb = 1'b0; stopPulse = 1'b0;
    waitCycles(3);
    check(!secTick && !counting, "R1 in reset", {secTick, counting}, 0);
    rstN = 1'b1;
    waitCycles(2);
    check(!secTick && !counting, "R1 after release", {secTick, counting}, 0);
  endtask

  task automatic tBlocked;
    int s, t;
    timeWrStb = 1'b1; #1;
    check(wrAccept == 1'b0, "R2 blocked strobe", wrAccept, 0);
    @(negedge clk);
    timeWrStb = 1'b0;
    doStop(1'b0, s);
    waitCycles(1);
    check(counting == 1'b0, "R3 no start", counting, 0);
    nextTick(t);
    check(t == -1, "R10 no tick idle", t, -1);
  endtask

  task automatic tStart;
    int s, t1, t2, w;
    wrEnable = 1'b1;
    timeWrStb = 1'b1; #1;
    check(wrAccept == 1'b1, "R2 passed strobe", wrAccept, 1);
    @(negedge clk);
    timeWrStb = 1'b0;
    check(counting == 1'b0, "R4 write alone", counting, 0);
    waitCycles(2);
    stopPulse = 1'b1; s = cyc;
    @(negedge clk);
    stopPulse = 1'b0;
    check(counting == 1'b1, "R4 start at stop", counting, 1);
    nextTick(t1);
    check(t1 - s == P + 1, "R5 first tick", t1 - s, P + 1);
    @(negedge clk);
    check(secTick == 1'b0, "R5 width", secTick, 0);
    nextTick(t2);
    w = t2 - t1;
    check(w == P, "R6 period", w, P);
  endtask

  task automatic tRealign;
    int s, t;
    waitCycles(P / 2);
    doStop(1'b1, s);
    nextTick(t);
    check(t - s == P + 1, "R7 realigned tick", t - s, P + 1);
  endtask

  task automatic tBareStop;
    int s, t0, t;
    nextTick(t0);
    waitCycles(P / 3);
    doStop(1'b0, s);
    nextTick(t);
    check(t - t0 == P, "R8 phase kept", t - t0, P);
  endtask

  task automatic tSticky;
    int s, t0, t;
    wrEnable = 1'b0;
    nextTick(t0);
    waitCycles(P / 4);
    doStop(1'b1, s);  // write is blocked, so this STOP must not realign
    check(counting == 1'b1, "R9 stays counting", counting, 1);
    nextTick(t);
    check(t - t0 == P, "R3 blocked write no realign", t - t0, P);
    check(counting == 1'b1, "R9 still counting", counting, 1);
  endtask

  initial begin
    tReset();
    tBlocked();
    tStart();
    tRealign();
    tBareStop();
    tSticky();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule